// File: doc/BRIEF.md
# Conditional-Write Attention Register

This block holds an attention register that two parties share. Hardware event sources set its upper bits to flag errors. A host on a simple synchronous control bus reads the register, clears the flags it has handled and drives the low stop-control bits. A plain read-modify-write would lose any flag that hardware raises between the host's read and its write. To avoid this, every host read of the register copies the live value into a hidden snapshot. A later host write changes a bit only where the live bit still equals its snapshot. Bits that hardware changed in the meantime keep their new value.

Next to the attention register sits an enable register. The host writes it directly and never needs to read it first. A single interrupt line is raised while any attention bit is set and its enable bit is also 1. The live register value is also driven out, so other logic can decode the stop bits.

Top module: `cwsr_top`

## Requirements
- R1: Reset is synchronous and active low. After reset the attention register holds 0x07, with the low three bits (stop bits) at 1 and the upper five bits (error bits) at 0. The enable register holds 0x00, `irq_o` is 0, and no snapshot is held.
- R2: A read with `bus_addr_i` = 0 returns the live attention value on `bus_rdata_o` in the same cycle. It also stores that value as the snapshot and marks the snapshot valid.
- R3: When a read at address 0 is followed directly by a write at address 0, with no hardware set in either cycle, all eight bits take the write data.
- R4: On a write with a valid snapshot, a bit whose live value differs from its snapshot keeps its live value. Each other bit takes the write data.
- R5: A write at address 0 with no valid snapshot has no effect. A snapshot is consumed by the first write at address 0 after it was taken.
- R6: Any access, read or write, at an address other than 0 invalidates the snapshot.
- R7: A 1 on bit n of `hw_set_i` sets attention bit n at the next clock edge. This holds even when a host write in the same cycle would clear that bit.
- R8: A write at address 1 loads the enable register unconditionally, and a read at address 1 returns its value. Reads at addresses 2 and 3 return 0.
- R9: `irq_o` is 1 exactly when some attention bit and the enable bit at the same position are both 1.
- R10: Reading the register and then writing 0x07 to it, with no intervening change, clears every error bit and sets every stop bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| bus_sel_i | input | 1 | Access strobe, one access per cycle |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address: 0 attention, 1 enable |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Read data for the current access |
| hw_set_i | input | WIDTH | Hardware set request per attention bit |
| status_o | output | WIDTH | Live attention register value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default values of WIDTH = 8, STOP_BITS = 3 and ADDR_W = 2. With these values the reset value is 0x07, and the two unused addresses, 2 and 3, can be reached. The bench reads address 2 to show that an access to an unused address also discards the snapshot. Because the width is eight bits, one vector can mix bits that were protected with bits that were written. One vector also places a hardware set against a host clear on the same bit.

// File: rtl/cwsr_pkg.sv
package cwsr_pkg;

    localparam int STATUS_ADDR = 0;
    localparam int NOTIFY_ADDR = 1;

    typedef struct packed {
        logic rd_status;
        logic wr_status;
        logic rd_notify;
        logic wr_notify;
        logic other_access;
    } bus_dec_t;

endpackage

// File: rtl/cwsr_bus_decode.sv
module cwsr_bus_decode #(
    parameter int ADDR_W = 2
) (
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output cwsr_pkg::bus_dec_t dec_o
);
    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(cwsr_pkg::STATUS_ADDR);
    localparam logic [ADDR_W-1:0] A_NOTIFY = ADDR_W'(cwsr_pkg::NOTIFY_ADDR);

    logic hit_status;
    logic hit_notify;

    always_comb begin
        hit_status         = (addr_i == A_STATUS);
        hit_notify         = (addr_i == A_NOTIFY);
        dec_o.rd_status    = sel_i && !wr_i && hit_status;
        dec_o.wr_status    = sel_i &&  wr_i && hit_status;
        dec_o.rd_notify    = sel_i && !wr_i && hit_notify;
        dec_o.wr_notify    = sel_i &&  wr_i && hit_notify;
        dec_o.other_access = sel_i && !hit_status;
    end
endmodule

// File: rtl/cwsr_status_reg.sv
module cwsr_status_reg #(
    parameter int WIDTH     = 8,
    parameter int STOP_BITS = 3
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  cwsr_pkg::bus_dec_t dec_i,
    input  logic [WIDTH-1:0]   wdata_i,
    input  logic [WIDTH-1:0]   hw_set_i,
    output logic [WIDTH-1:0]   status_o,
    output logic               cmp_valid_o
);
    localparam logic [WIDTH-1:0] RST_VAL = WIDTH'((1 << STOP_BITS) - 1);

    typedef struct packed {
        logic [WIDTH-1:0] status;
        logic [WIDTH-1:0] cmp;
        logic             valid;
    } st_t;

    st_t st_q;
    st_t st_d;
    logic [WIDTH-1:0] match;

    always_comb begin
        st_d  = st_q;
        match = ~(st_q.status ^ st_q.cmp);
        if (dec_i.rd_status) begin
            st_d.cmp   = st_q.status;
            st_d.valid = 1'b1;
        end
        if (dec_i.other_access) begin
            st_d.valid = 1'b0;
        end
        if (dec_i.wr_status) begin
            if (st_q.valid) begin
                st_d.status = (st_q.status & ~match) | (wdata_i & match);
            end
            st_d.valid = 1'b0;
        end
        st_d.status = st_d.status | hw_set_i;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q.status <= RST_VAL;
            st_q.cmp    <= '0;
            st_q.valid  <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign status_o    = st_q.status;
    assign cmp_valid_o = st_q.valid;
endmodule

// File: rtl/cwsr_notify_reg.sv
module cwsr_notify_reg #(
    parameter int WIDTH = 8
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  cwsr_pkg::bus_dec_t dec_i,
    input  logic [WIDTH-1:0]   wdata_i,
    output logic [WIDTH-1:0]   notify_o
);
    logic [WIDTH-1:0] notify_d;
    logic [WIDTH-1:0] notify_q;

    always_comb begin
        notify_d = notify_q;
        if (dec_i.wr_notify) begin
            notify_d = wdata_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            notify_q <= '0;
        end else begin
            notify_q <= notify_d;
        end
    end

    assign notify_o = notify_q;
endmodule

// File: rtl/cwsr_irq.sv
module cwsr_irq #(
    parameter int WIDTH = 8
) (
    input  logic [WIDTH-1:0] status_i,
    input  logic [WIDTH-1:0] enable_i,
    output logic             irq_o
);
    logic [WIDTH-1:0] pending;

    for (genvar b = 0; b < WIDTH; b++) begin : g_pend
        assign pending[b] = status_i[b] & enable_i[b];
    end

    assign irq_o = |pending;
endmodule

// File: rtl/cwsr_top.sv
module cwsr_top #(
    parameter int WIDTH     = 8,
    parameter int STOP_BITS = 3,
    parameter int ADDR_W    = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_sel_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [WIDTH-1:0]  bus_wdata_i,
    output logic [WIDTH-1:0]  bus_rdata_o,
    input  logic [WIDTH-1:0]  hw_set_i,
    output logic [WIDTH-1:0]  status_o,
    output logic              irq_o
);
    cwsr_pkg::bus_dec_t dec;
    logic [WIDTH-1:0]   status_q;
    logic [WIDTH-1:0]   notify_q;
    logic               cmp_valid;

    cwsr_bus_decode #(.ADDR_W(ADDR_W)) dec_i (
        .sel_i  (bus_sel_i),
        .wr_i   (bus_wr_i),
        .addr_i (bus_addr_i),
        .dec_o  (dec)
    );

    cwsr_status_reg #(.WIDTH(WIDTH), .STOP_BITS(STOP_BITS)) stat_i (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .dec_i       (dec),
        .wdata_i     (bus_wdata_i),
        .hw_set_i    (hw_set_i),
        .status_o    (status_q),
        .cmp_valid_o (cmp_valid)
    );

    cwsr_notify_reg #(.WIDTH(WIDTH)) ntf_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .dec_i    (dec),
        .wdata_i  (bus_wdata_i),
        .notify_o (notify_q)
    );

    cwsr_irq #(.WIDTH(WIDTH)) irq_i (
        .status_i (status_q),
        .enable_i (notify_q),
        .irq_o    (irq_o)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (dec.rd_status) begin
            bus_rdata_o = status_q;
        end else if (dec.rd_notify) begin
            bus_rdata_o = notify_q;
        end
    end

    assign status_o = status_q;
endmodule

// File: rtl/cwsr_checker.sv
module cwsr_checker #(
    parameter int WIDTH     = 8,
    parameter int STOP_BITS = 3,
    parameter int ADDR_W    = 2
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              bus_sel_i,
    input logic              bus_wr_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [WIDTH-1:0]  bus_wdata_i,
    input logic [WIDTH-1:0]  hw_set_i,
    input logic [WIDTH-1:0]  status_q,
    input logic [WIDTH-1:0]  notify_q,
    input logic              cmp_valid,
    input logic              irq_o
);
    localparam logic [WIDTH-1:0] RST_VAL = WIDTH'((1 << STOP_BITS) - 1);

    logic rd_st;
    logic wr_st;
    logic wr_nt;
    logic other;
    logic no_hw;

    assign rd_st = bus_sel_i && !bus_wr_i && (bus_addr_i == ADDR_W'(0));
    assign wr_st = bus_sel_i &&  bus_wr_i && (bus_addr_i == ADDR_W'(0));
    assign wr_nt = bus_sel_i &&  bus_wr_i && (bus_addr_i == ADDR_W'(1));
    assign other = bus_sel_i && (bus_addr_i != ADDR_W'(0));
    assign no_hw = (hw_set_i == '0);

    AST_RESET_VALUE: assert property (@(posedge clk_i)
        !rst_ni |=> (status_q == RST_VAL && notify_q == '0 && !cmp_valid)); // R1

    AST_CLEAN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_st && no_hw) ##1 (wr_st && no_hw) |=> status_q == $past(bus_wdata_i)); // R3

    AST_STALE_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_st && !cmp_valid && no_hw) |=> $stable(status_q)); // R5

    AST_OTHER_ACCESS_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        other |=> !cmp_valid); // R6

    AST_HW_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !no_hw |=> ((status_q & $past(hw_set_i)) == $past(hw_set_i))); // R7

    AST_NOTIFY_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_nt |=> notify_q == $past(bus_wdata_i)); // R8

    AST_IRQ_MASKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (notify_q == '0) |-> !irq_o); // R9
endmodule

bind cwsr_top cwsr_checker #(
    .WIDTH(WIDTH), .STOP_BITS(STOP_BITS), .ADDR_W(ADDR_W)
) chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .bus_sel_i   (bus_sel_i),
    .bus_wr_i    (bus_wr_i),
    .bus_addr_i  (bus_addr_i),
    .bus_wdata_i (bus_wdata_i),
    .hw_set_i    (hw_set_i),
    .status_q    (status_q),
    .notify_q    (notify_q),
    .cmp_valid   (cmp_valid),
    .irq_o       (irq_o)
);

// File: tb/cwsr_top_tb_top.sv
`timescale 1ns/1ps
module cwsr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       sel, wr;
    logic [1:0] addr;
    logic [7:0] wdata, hw, rdata, status;
    logic       irq;
    int         n_chk = 0;
    int         n_err = 0;

    always #2 clk = ~clk;

    cwsr_top dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_sel_i(sel), .bus_wr_i(wr),
        .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .hw_set_i(hw), .status_o(status), .irq_o(irq)
    );

    typedef struct packed {
        logic       sel;
        logic       wr;
        logic [1:0] addr;
        logic [7:0] wdata;
        logic [7:0] hw;
        logic [7:0] exp_st;
        logic       exp_irq;
        logic [7:0] exp_rd;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h07, 1'b0, 8'h07}, // R2 read
        '{1'b1, 1'b1, 2'd0, 8'hF0, 8'h00, 8'hF0, 1'b0, 8'h00}, // R3 full write
        '{1'b1, 1'b1, 2'd0, 8'h00, 8'h00, 8'hF0, 1'b0, 8'h00}, // R5 snapshot consumed
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'hF0, 1'b0, 8'hF0}, // R2 read
        '{1'b0, 1'b0, 2'd0, 8'h00, 8'h08, 8'hF8, 1'b0, 8'h00}, // R7 hw set
        '{1'b1, 1'b1, 2'd0, 8'h00, 8'h00, 8'h08, 1'b0, 8'h00}, // R4 bit3 protected
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h08, 1'b0, 8'h08}, // R2 read
        '{1'b1, 1'b1, 2'd1, 8'hFF, 8'h00, 8'h08, 1'b1, 8'h00}, // R6 other access
        '{1'b1, 1'b1, 2'd0, 8'h00, 8'h00, 8'h08, 1'b1, 8'h00}, // R6 write ignored
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h08, 1'b1, 8'h08}, // R2 read
        '{1'b1, 1'b1, 2'd0, 8'h00, 8'h08, 8'h08, 1'b1, 8'h00}, // R7 hw beats clear
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h08, 1'b1, 8'h08}, // R2 read
        '{1'b1, 1'b1, 2'd0, 8'h07, 8'h00, 8'h07, 1'b1, 8'h00}, // R10 stop mode
        '{1'b1, 1'b0, 2'd0, 8'h00, 8'h00, 8'h07, 1'b1, 8'h07}, // R2 read
        '{1'b1, 1'b0, 2'd2, 8'h00, 8'h00, 8'h07, 1'b1, 8'h00}, // R6/R8 unused addr
        '{1'b1, 1'b1, 2'd0, 8'h80, 8'h00, 8'h07, 1'b1, 8'h00}  // R6 write ignored
    };

    task automatic check(input bit ok, input string req, input logic [7:0] act,
                         input logic [7:0] exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic bus(input logic s, input logic w, input logic [1:0] a,
                       input logic [7:0] d, input logic [7:0] h,
                       output logic [7:0] rd);
        @(negedge clk);
        sel = s; wr = w; addr = a; wdata = d; hw = h;
        #1 rd = rdata;
        @(negedge clk);
        sel = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'h00; hw = 8'h00;
    endtask

    initial begin
        #(200000 * 4);
        n_err++;
        $display("FAIL watchdog: actual %02h expected %02h", 8'h00, 8'h01);
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [7:0] rd;
        rst_n = 1'b0; sel = 1'b0; wr = 1'b0; addr = 2'd0; wdata = 8'h00; hw = 8'h00;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check(status == 8'h07, "R1 reset status", status, 8'h07);
        check(irq == 1'b0, "R1 reset irq", {7'd0, irq}, 8'h00);
        bus(1'b1, 1'b0, 2'd1, 8'h00, 8'h00, rd);
        check(rd == 8'h00, "R1 reset enable", rd, 8'h00);
        bus(1'b1, 1'b1, 2'd0, 8'hFF, 8'h00, rd);
        check(status == 8'h07, "R1 no snapshot after reset", status, 8'h07);

        for (int i = 0; i < NV; i++) begin
            bus(VEC[i].sel, VEC[i].wr, VEC[i].addr, VEC[i].wdata, VEC[i].hw, rd);
            if (VEC[i].sel && !VEC[i].wr)
                check(rd == VEC[i].exp_rd, $sformatf("R2/R8 vec%0d rdata", i), rd, VEC[i].exp_rd);
            check(status == VEC[i].exp_st, $sformatf("R3-vec%0d status", i), status, VEC[i].exp_st);
            check(irq == VEC[i].exp_irq, $sformatf("R9 vec%0d irq", i),
                  {7'd0, irq}, {7'd0, VEC[i].exp_irq});
        end

        // R8: direct enable write and readback
        bus(1'b1, 1'b1, 2'd1, 8'h80, 8'h00, rd);
        bus(1'b1, 1'b0, 2'd1, 8'h00, 8'h00, rd);
        check(rd == 8'h80, "R8 enable readback", rd, 8'h80);
        check(irq == 1'b0, "R9 irq masked", {7'd0, irq}, 8'h00);
        bus(1'b1, 1'b0, 2'd3, 8'h00, 8'h00, rd);
        check(rd == 8'h00, "R8 addr3 reads zero", rd, 8'h00);
        // R7 and R9: hardware set on an enabled bit
        bus(1'b0, 1'b0, 2'd0, 8'h00, 8'h80, rd);
        check(status == 8'h87, "R7 hw set", status, 8'h87);
        check(irq == 1'b1, "R9 irq raised", {7'd0, irq}, 8'h01);
        // R10: clear after read
        bus(1'b1, 1'b0, 2'd0, 8'h00, 8'h00, rd);
        check(rd == 8'h87, "R2 live read", rd, 8'h87);
        bus(1'b1, 1'b1, 2'd0, 8'h07, 8'h00, rd);
        check(status == 8'h07, "R10 errors cleared", status, 8'h07);
        check(irq == 1'b0, "R9 irq dropped", {7'd0, irq}, 8'h00);
        // R9: enable cleared masks new error
        bus(1'b1, 1'b1, 2'd1, 8'h00, 8'h40, rd);
        check(status == 8'h47, "R7 hw set during enable write", status, 8'h47);
        check(irq == 1'b0, "R9 irq masked by zero enable", {7'd0, irq}, 8'h00);
        // R1: reset mid-run
        bus(1'b1, 1'b1, 2'd1, 8'hFF, 8'h00, rd);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check(status == 8'h07, "R1 reset mid-run", status, 8'h07);
        bus(1'b1, 1'b0, 2'd1, 8'h00, 8'h00, rd);
        check(rd == 8'h00, "R1 enable cleared", rd, 8'h00);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule